// File: doc/BRIEF.md
# Stipple and Blit Pixel Write Engine

This block speeds up drawing into a framebuffer that stores one byte per pixel. Software reaches it through a small register port of 32-bit words. The destination pixel is not sent as data. It is carried in the access address, so a single register write both names the target pixel and gives the work to do. Three kinds of write are decoded. A colour write sets the fill colour. A stipple write turns each set bit of a 32-bit pattern into one fill-colour pixel. A blit write either copies a run of pixels from a source address or fills that run with the colour.

Once an operation is accepted, the engine drives a simple synchronous memory port. It issues one access per cycle and keeps `busy` high until the run is complete. While busy it stalls further register traffic. When the run ends it emits a one-cycle completion pulse with the first pixel address and the length of the touched region, which display refresh logic can use to redraw that region.

Top module: `pxa_engine`

## Requirements
- R1: After reset `busy`, `mem_req`, `done` and `rd_valid` are 0 and `reg_ready` is 1.
- R2: A stipple write maps data bit 31 to destination pixel +0, bit 30 to +1, and so on down to bit 0 at +31. Each set bit writes the fill colour. Each clear bit leaves its pixel untouched.
- R3: Register address bits [PIX_AW+2:3] give the destination pixel, and bits [2:0] are ignored. Bits [PIX_AW+4:PIX_AW+3] select the function: 0 is stipple, 1 is blit, 2 loads the fill colour from data[COL_W-1:0], and 3 has no effect.
- R4: A blit write whose data[23:0] is not all ones copies data[28:24]+1 pixels. The source starts at the low PIX_AW bits of data[23:0]. Pixels are copied in ascending order, and each pixel takes one read cycle followed by one write cycle, so overlapping forward copies propagate.
- R5: A blit write with data[23:0] = 0xFFFFFF fills data[28:24]+1 pixels with the fill colour, one pixel per cycle.
- R6: Only accesses with `reg_size` = 2 (32-bit) act. Other sizes complete the handshake without changing any state.
- R7: An accepted read produces `rd_valid` in the next cycle with `rd_data` = 0 and starts nothing.
- R8: `reg_ready` is low from the cycle after an operation is accepted until the cycle in which `done` pulses. A request held during that time is accepted at the first edge where ready is high.
- R9: `done` pulses for exactly one cycle when an operation ends, and `busy` is already low in that cycle. `done_addr` gives the destination start, and `done_len` gives 32 for a stipple or the run length for a blit.
- R10: Destination and source addresses wrap modulo 2^PIX_AW.
- R11: A stipple always takes 32 cycles from acceptance to `done`, including when the pattern is zero. A fill of L pixels takes L cycles, and a copy of L pixels takes 2L cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_valid | input | 1 | Register access request |
| reg_ready | output | 1 | Access accepted when high with reg_valid |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_size | input | 2 | log2 of access bytes; only 2 acts |
| reg_addr | input | REG_AW | Access address (function select and destination) |
| reg_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read response strobe |
| rd_data | output | 32 | Read response data (always 0) |
| busy | output | 1 | Operation in progress |
| mem_req | output | 1 | Framebuffer access this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | PIX_AW | Framebuffer pixel address |
| mem_wdata | output | COL_W | Pixel write data |
| mem_rdata | input | COL_W | Read data, valid the cycle after a read request |
| done | output | 1 | Completion pulse |
| done_addr | output | PIX_AW | First pixel of the touched region |
| done_len | output | 6 | Pixel count of the touched region |

## Verification
The bench builds the engine with PIX_AW = 12. This gives a 4096-pixel framebuffer model that is compared in full against a reference after every operation, so a stray write anywhere is detected. The small address space also puts the top-of-memory wrap of both destination and source within reach of ordinary random destinations. Random stipple, fill and copy runs, including overlapping copies, are checked for contents, latency and the reported dirty region.

// File: rtl/pxa_pkg.sv
// Shared constants and types for the pixel write engine.
// Assumes a run length of 32, matching the 32-bit register data word.
package pxa_pkg;
    localparam int RUN_LEN = 32;
    localparam int LEN_W   = $clog2(RUN_LEN);
    localparam int CNT_W   = LEN_W + 1;
    localparam int SRC_W   = 24;
    localparam int DATA_W  = 32;
    localparam logic [1:0] SIZE_WORD = 2'd2;

    typedef enum logic [1:0] {
        SEL_STIP  = 2'd0,
        SEL_BLIT  = 2'd1,
        SEL_COLOR = 2'd2,
        SEL_NONE  = 2'd3
    } sel_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STIP,
        ST_FILL,
        ST_CRD,
        ST_CWR
    } st_e;
endpackage

// File: rtl/pxa_decode.sv
// Request decoder: splits an accepted register access into operation starts.
// Purely combinational. Assumes PIX_AW <= 24 so a source fits the data field.
module pxa_decode
    import pxa_pkg::*;
#(
    parameter int PIX_AW = 20,
    parameter int COL_W  = 8,
    parameter int REG_AW = PIX_AW + 5
) (
    input  logic               accept,
    input  logic               wr,
    input  logic [1:0]         size,
    input  logic [REG_AW-1:0]  addr,
    input  logic [DATA_W-1:0]  data,
    output logic               go_stip,
    output logic               go_blit,
    output logic               go_fill,
    output logic               color_we,
    output logic [COL_W-1:0]   color_val,
    output logic [PIX_AW-1:0]  dst,
    output logic [PIX_AW-1:0]  src,
    output logic [LEN_W-1:0]   len_m1,
    output logic [RUN_LEN-1:0] pattern
);
    sel_e sel;
    logic act;

    // Field extraction and function select.
    always_comb begin
        sel       = sel_e'(addr[PIX_AW+4:PIX_AW+3]);
        act       = accept && wr && (size == SIZE_WORD);
        dst       = addr[PIX_AW+2:3];
        src       = data[PIX_AW-1:0];
        len_m1    = data[SRC_W+LEN_W-1:SRC_W];
        pattern   = data[RUN_LEN-1:0];
        color_val = data[COL_W-1:0];
        go_stip   = act && (sel == SEL_STIP);
        go_blit   = act && (sel == SEL_BLIT);
        color_we  = act && (sel == SEL_COLOR);
        go_fill   = &data[SRC_W-1:0];
    end
endmodule

// File: rtl/pxa_seq.sv
// Operation sequencer: walks a stipple, fill or copy run one access per
// cycle on the framebuffer port, then reports the touched region.
// Assumes memory read data is valid one cycle after a read request.
module pxa_seq
    import pxa_pkg::*;
#(
    parameter int PIX_AW = 20,
    parameter int COL_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go_stip,
    input  logic               go_blit,
    input  logic               go_fill,
    input  logic [PIX_AW-1:0]  dst,
    input  logic [PIX_AW-1:0]  src,
    input  logic [LEN_W-1:0]   len_m1,
    input  logic [RUN_LEN-1:0] pattern,
    input  logic [COL_W-1:0]   color,
    output logic               busy,
    output logic               mem_req,
    output logic               mem_we,
    output logic [PIX_AW-1:0]  mem_addr,
    output logic [COL_W-1:0]   mem_wdata,
    input  logic [COL_W-1:0]   mem_rdata,
    output logic               done,
    output logic [PIX_AW-1:0]  done_addr,
    output logic [CNT_W-1:0]   done_len
);
    st_e                st;
    logic [LEN_W-1:0]   idx;
    logic [LEN_W-1:0]   last_q;
    logic [PIX_AW-1:0]  dst_q;
    logic [PIX_AW-1:0]  src_q;
    logic [RUN_LEN-1:0] pat_q;
    logic [COL_W-1:0]   col_q;
    logic               at_last;
    logic [PIX_AW-1:0]  idx_ext;

    // Run position helpers.
    always_comb begin
        at_last = (idx == last_q);
        idx_ext = PIX_AW'(idx);
    end

    // State walk, run registers and completion report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            idx       <= '0;
            last_q    <= '0;
            dst_q     <= '0;
            src_q     <= '0;
            pat_q     <= '0;
            col_q     <= '0;
            done      <= 1'b0;
            done_addr <= '0;
            done_len  <= '0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (go_stip || go_blit) begin
                        dst_q <= dst;
                        src_q <= src;
                        col_q <= color;
                        pat_q <= pattern;
                        idx   <= '0;
                        if (go_stip) begin
                            st     <= ST_STIP;
                            last_q <= LEN_W'(RUN_LEN - 1);
                        end else begin
                            st     <= go_fill ? ST_FILL : ST_CRD;
                            last_q <= len_m1;
                        end
                    end
                end
                ST_CRD: st <= ST_CWR;
                default: begin
                    if (st == ST_STIP) pat_q <= pat_q << 1;
                    if (at_last) begin
                        st        <= ST_IDLE;
                        done      <= 1'b1;
                        done_addr <= dst_q;
                        done_len  <= CNT_W'(last_q) + CNT_W'(1);
                    end else begin
                        idx <= idx + LEN_W'(1);
                        if (st == ST_CWR) st <= ST_CRD;
                    end
                end
            endcase
        end
    end

    // Framebuffer port drive for the current step.
    always_comb begin
        busy      = (st != ST_IDLE);
        mem_req   = ((st == ST_STIP) && pat_q[RUN_LEN-1]) || (st == ST_FILL)
                    || (st == ST_CRD) || (st == ST_CWR);
        mem_we    = (st != ST_CRD);
        mem_addr  = (st == ST_CRD) ? (src_q + idx_ext) : (dst_q + idx_ext);
        mem_wdata = (st == ST_CWR) ? mem_rdata : col_q;
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);
    p_read_then_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && st == ST_CWR) |-> $past(mem_req && !mem_we));
    p_fill_ascends_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FILL && $past(st == ST_FILL)) |-> mem_addr == $past(mem_addr) + PIX_AW'(1));
    p_no_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (go_stip || go_blit) |-> !busy);
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (done_len >= CNT_W'(1) && done_len <= CNT_W'(RUN_LEN) && !busy));
endmodule

// File: rtl/pxa_engine.sv
// Top of the pixel write engine: register handshake, fill colour, read
// response and the operation sequencer. Stalls all access while busy.
module pxa_engine
    import pxa_pkg::*;
#(
    parameter int PIX_AW = 20,
    parameter int COL_W  = 8,
    parameter int REG_AW = PIX_AW + 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_valid,
    output logic              reg_ready,
    input  logic              reg_write,
    input  logic [1:0]        reg_size,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [PIX_AW-1:0] mem_addr,
    output logic [COL_W-1:0]  mem_wdata,
    input  logic [COL_W-1:0]  mem_rdata,
    output logic              done,
    output logic [PIX_AW-1:0] done_addr,
    output logic [5:0]        done_len
);
    logic               accept;
    logic               go_stip, go_blit, go_fill, color_we;
    logic [COL_W-1:0]   color_val, color_q;
    logic [PIX_AW-1:0]  dec_dst, dec_src;
    logic [LEN_W-1:0]   dec_len;
    logic [RUN_LEN-1:0] dec_pat;
    logic [CNT_W-1:0]   len_w;

    // Handshake: accept only when the sequencer is idle.
    always_comb begin
        reg_ready = !busy;
        accept    = reg_valid && reg_ready;
        done_len  = 6'(len_w);
    end

    pxa_decode #(.PIX_AW(PIX_AW), .COL_W(COL_W), .REG_AW(REG_AW)) u_dec (
        .accept(accept), .wr(reg_write), .size(reg_size), .addr(reg_addr),
        .data(reg_wdata), .go_stip(go_stip), .go_blit(go_blit),
        .go_fill(go_fill), .color_we(color_we), .color_val(color_val),
        .dst(dec_dst), .src(dec_src), .len_m1(dec_len), .pattern(dec_pat)
    );

    // Fill colour register.
    always_ff @(posedge clk) begin
        if (!rst_n)        color_q <= '0;
        else if (color_we) color_q <= color_val;
    end

    // Read response: every read completes next cycle with zero data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= accept && !reg_write;
            rd_data  <= '0;
        end
    end

    pxa_seq #(.PIX_AW(PIX_AW), .COL_W(COL_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .go_stip(go_stip), .go_blit(go_blit),
        .go_fill(go_fill), .dst(dec_dst), .src(dec_src), .len_m1(dec_len),
        .pattern(dec_pat), .color(color_q), .busy(busy), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .done(done), .done_addr(done_addr),
        .done_len(len_w)
    );

    p_rd_follows_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(reg_valid && reg_ready && !reg_write));
    p_busy_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && busy) |=> !$rose(rd_valid));
endmodule

// File: tb/sim_pxa_engine.sv
module sim_pxa_engine;
    localparam int PAW = 12;
    localparam int NPIX = 1 << PAW;
    localparam int RAW = PAW + 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_valid = 1'b0, reg_write = 1'b0;
    logic [1:0] reg_size = 2'd2;
    logic [RAW-1:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic reg_ready, rd_valid, busy, mem_req, mem_we, done;
    logic [31:0] rd_data;
    logic [PAW-1:0] mem_addr, done_addr;
    logic [7:0] mem_wdata, rdq;
    logic [5:0] done_len;

    logic [7:0] fb [NPIX];
    logic [7:0] mdl [NPIX];
    int total = 0, bad = 0;
    logic [7:0] cur_col = 8'h00;
    int got_addr, got_len;

    always #2 clk = ~clk;

    pxa_engine #(.PIX_AW(PAW), .COL_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_ready(reg_ready),
        .reg_write(reg_write), .reg_size(reg_size), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(rdq), .done(done),
        .done_addr(done_addr), .done_len(done_len)
    );

    // framebuffer model: write on request, read data one cycle later
    always @(posedge clk) begin
        if (mem_req && mem_we) fb[mem_addr] <= mem_wdata;
        if (mem_req && !mem_we) rdq <= fb[mem_addr];
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int mism();
        int n = 0;
        for (int i = 0; i < NPIX; i++) if (fb[i] !== mdl[i]) n++;
        return n;
    endfunction

    task automatic put(input logic [1:0] sel, input int dst, input logic [31:0] data,
                       input logic [1:0] size, input bit wr);
        @(negedge clk);
        while (!reg_ready) @(negedge clk);
        reg_valid = 1'b1;
        reg_write = wr;
        reg_size  = size;
        reg_addr  = {sel, PAW'(dst), 3'($urandom_range(0, 7))};
        reg_wdata = data;
        @(posedge clk);
        @(negedge clk);
        reg_valid = 1'b0;
    endtask

    // counts edges after the accepting edge until done is seen
    task automatic wait_done(input int limit, output int cyc, output bit seen,
                             output bit ready_ok);
        cyc = 0; seen = 0; ready_ok = 1;
        while (cyc < limit && !seen) begin
            if (cyc > 0 && reg_ready) ready_ok = 0;
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (done) begin
                seen = 1;
                got_addr = int'(done_addr);
                got_len = int'(done_len);
                if (!reg_ready || busy) ready_ok = 0;
            end
        end
    endtask

    task automatic set_color(input logic [7:0] c);
        put(2'd2, $urandom_range(0, NPIX - 1), {24'($urandom), c}, 2'd2, 1'b1);
        cur_col = c;
    endtask

    task automatic op_stip(input int dst, input logic [31:0] pat);
        int cyc; bit seen, rok;
        for (int i = 0; i < 32; i++)
            if (pat[31 - i]) mdl[(dst + i) % NPIX] = cur_col;
        put(2'd0, dst, pat, 2'd2, 1'b1);
        wait_done(100, cyc, seen, rok);
        check(seen, "R9", "stipple done seen", int'(seen), 1);
        check(cyc == 32, "R11", "stipple cycles", cyc, 32);
        check(got_addr == dst, "R9", "stipple done_addr", got_addr, dst);
        check(got_len == 32, "R9", "stipple done_len", got_len, 32);
        check(rok, "R8", "ready low while stipple busy", int'(rok), 1);
        check(mism() == 0, "R2", "stipple pixels (R10 wrap)", mism(), 0);
    endtask

    task automatic op_blit(input int dst, input logic [31:0] data);
        int cyc, len, src, expc; bit seen, rok, fill;
        len = int'(data[28:24]) + 1;
        fill = (data[23:0] == 24'hFFFFFF);
        src = int'(data[PAW-1:0]);
        for (int i = 0; i < len; i++)
            mdl[(dst + i) % NPIX] = fill ? cur_col : mdl[(src + i) % NPIX];
        expc = fill ? len : 2 * len;
        put(2'd1, dst, data, 2'd2, 1'b1);
        wait_done(200, cyc, seen, rok);
        check(seen, "R9", "blit done seen", int'(seen), 1);
        check(cyc == expc, "R11", "blit cycles", cyc, expc);
        check(got_addr == dst, "R9", "blit done_addr", got_addr, dst);
        check(got_len == len, "R9", "blit done_len", got_len, len);
        check(rok, "R8", "ready low while blit busy", int'(rok), 1);
        if (fill) check(mism() == 0, "R5", "fill pixels", mism(), 0);
        else      check(mism() == 0, "R4", "copy pixels", mism(), 0);
    endtask

    function automatic logic [31:0] bdata(input int len, input int src, input bit fill);
        return {3'b000, 5'(len - 1), fill ? 24'hFFFFFF : 24'(src)};
    endfunction

    initial begin
        #(4 * 150000);
        check(0, "WDOG", "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int cyc; bit seen, rok;
        void'($urandom(32'd4711));
        for (int i = 0; i < NPIX; i++) begin
            fb[i] = 8'((i * 7) ^ (i >> 3));
            mdl[i] = fb[i];
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(!busy && reg_ready && !mem_req && !done && !rd_valid, "R1",
              "reset outputs", {busy, reg_ready, mem_req, done, rd_valid}, 5'b01000);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && reg_ready && !mem_req, "R1", "after reset release",
              {busy, reg_ready, mem_req}, 3'b010);

        // R2 / R3 directed stipple
        set_color(8'h5A);
        op_stip(100, 32'h8000_0001);
        op_stip(300, 32'hA5C3_0F81);
        op_stip(500, 32'h0000_0000);   // R11 zero pattern still 32 cycles
        // R5 fills
        op_blit(200, bdata(32, 0, 1));
        op_blit(260, bdata(1, 0, 1));
        // R4 copies, including overlapping forward copy
        op_blit(700, bdata(5, 10, 0));
        op_blit(601, bdata(8, 600, 0));
        op_blit(900, {3'b000, 5'd3, 12'hABC, 12'd40});   // upper source bits ignored
        // R10 wrap of destination and source
        set_color(8'hC3);
        op_blit(NPIX - 6, bdata(10, 0, 1));
        op_stip(NPIX - 16, 32'hFFFF_FFFF);
        op_blit(40, bdata(12, NPIX - 4, 0));

        // R6 non-word sizes do nothing
        put(2'd2, 0, 32'h0000_0011, 2'd0, 1'b1);
        put(2'd0, 1000, 32'hFFFF_FFFF, 2'd1, 1'b1);
        wait_done(40, cyc, seen, rok);
        check(!seen, "R6", "no operation from narrow stipple", int'(seen), 0);
        check(mism() == 0, "R6", "memory untouched", mism(), 0);
        op_blit(1100, bdata(4, 0, 1));   // still old colour C3
        // R3 select 3 has no effect
        put(2'd3, 1200, 32'hFFFF_FFFF, 2'd2, 1'b1);
        wait_done(40, cyc, seen, rok);
        check(!seen && mism() == 0, "R3", "select 3 no effect", int'(seen), 0);

        // R7 read returns zero next cycle
        put(2'd1, 5, 32'h1234_5678, 2'd2, 1'b0);
        check(rd_valid && rd_data == 0, "R7", "read response", int'(rd_data), 0);
        check(!busy, "R7", "read starts nothing", int'(busy), 0);
        @(negedge clk);
        check(!rd_valid, "R7", "rd_valid single cycle", int'(rd_valid), 0);

        // R8 held request stalls until done
        put(2'd1, 1300, bdata(6, 0, 1), 2'd2, 1'b1);
        for (int i = 1300; i < 1306; i++) mdl[i] = cur_col;
        reg_valid = 1'b1; reg_write = 1'b1; reg_size = 2'd2;
        reg_addr = {2'd2, PAW'(0), 3'd0}; reg_wdata = 32'h0000_0077;
        wait_done(50, cyc, seen, rok);
        check(seen && cyc == 6, "R8", "held write waits for done", cyc, 6);
        check(rok, "R8", "ready low while held", int'(rok), 1);
        @(posedge clk);
        @(negedge clk);
        reg_valid = 1'b0;
        cur_col = 8'h77;
        check(mism() == 0, "R8", "fill before stall unchanged", mism(), 0);
        op_blit(1400, bdata(3, 0, 1));

        // random mix
        for (int k = 0; k < 60; k++) begin
            int kind = $urandom_range(0, 3);
            int d = $urandom_range(0, NPIX - 1);
            int l = $urandom_range(1, 32);
            case (kind)
                0: set_color(8'($urandom));
                1: op_stip(d, $urandom);
                2: op_blit(d, bdata(l, 0, 1));
                default: op_blit(d, bdata(l, $urandom_range(0, NPIX - 1), 0));
            endcase
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule